// File: doc/BRIEF.md
# Prioritized External Interrupt Request Controller

This block takes eight external interrupt inputs and turns them into one prioritized request for a CPU. Each input has its own detection mode, chosen from four: low level, falling edge, rising edge, high level. Each input also has its own 4-bit priority level. A detected request is latched as pending. Every cycle the block picks the pending source with the highest level. It presents that source only if its level is strictly above the current CPU interrupt mask. The source index and level are registered.

The CPU reports that it has taken an interrupt with a one-cycle accept strobe that carries the accepted source index. Edge-detected requests are released by an accept of their own index. Level-detected requests are released differently. They stay latched after the pin returns to its inactive level, and are dropped by any accept (their own or another source's) or by setting the source's mask bit. If a level pin is still active after such a drop, the request latches again one cycle later. The pins are expected to arrive already synchronized to the clock.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The 2-bit mode of source i sits at bits [2i+1:2i] of `mode_i`. Code 10 latches a request on a 0-to-1 change of the pin, and code 01 latches one on a 1-to-0 change. In either edge mode, a change in the opposite direction latches nothing.
- R2: Code 00 latches a request while the pin is 0, and code 11 latches one while the pin is 1. The opposite pin level latches nothing.
- R3: A level-mode request stays pending after its pin returns to the inactive level, until it is released as stated in R4 or R5.
- R4: Any accept strobe releases every level-mode pending request, including one from a source other than the accepted index. If the pin is still active, the request is pending again on the cycle after the release.
- R5: While bit i of `src_mask_i` is 1, source i is not pending, its pin activity is ignored, and any request it already held is dropped. An edge that occurs while the bit is 1 is not recovered when the bit returns to 0.
- R6: The level of source i is `prio_i[4i+3:4i]`. A level of 0 drops the source's pending request and ignores its pin, and a later nonzero level does not recover an edge seen at level 0.
- R7: A pending source is presented only when its level is strictly greater than `cpu_mask_i`.
- R8: Among the presentable sources, the highest level wins. On equal levels, the lower source index wins. `irq_level_o` carries the winner's level.
- R9: An edge-mode pending request is cleared by an accept whose `accept_id_i` equals its index. An accept of any other index leaves it pending.
- R10: After reset, `irq_valid_o`, `irq_id_o` and `irq_level_o` are all 0. When no source is presented, all three outputs read 0.
- R11: A qualifying pin change that is sampled on one rising edge appears on the outputs after the following rising edge. A change of `cpu_mask_i` takes effect on the outputs after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Synchronized external interrupt inputs |
| mode_i | input | 16 | Detection mode, 2 bits per source |
| prio_i | input | 32 | Priority level, 4 bits per source |
| cpu_mask_i | input | 4 | Current CPU interrupt mask level |
| src_mask_i | input | 8 | Per-source mask bits, 1 masks |
| accept_i | input | 1 | One-cycle strobe: the CPU took an interrupt |
| accept_id_i | input | 3 | Source index taken with the strobe |
| irq_valid_o | output | 1 | A request is presented |
| irq_id_o | output | 3 | Index of the presented source |
| irq_level_o | output | 4 | Level of the presented source |

## Verification
The assertions assume three things about the inputs. The pins are already synchronous to `clk`. `accept_i` is a single-cycle pulse, and it carries an index that is in range. The priority and mode values stay steady in the cycle that an accept is taken. The stimulus respects this by changing every input only on the falling clock edge and by raising each accept for exactly one cycle. It also sets a new mode or priority only when no accept is in flight, so that each release and each re-latch can be placed on a known cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_RISE = 2'b10,
    DET_HIGH = 2'b11
  } det_mode_e;

  function automatic logic mode_is_level(det_mode_e m);
    return (m == DET_LOW) || (m == DET_HIGH);
  endfunction

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
  import irq_prio_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  det_mode_e        mode_i,
  input  logic [LVL_W-1:0] prio_i,
  input  logic             mask_i,
  input  logic             acc_hit_i,
  input  logic             acc_any_i,
  output logic             pending_o
);

  logic prev_q;
  logic pend_q;
  logic hit;
  logic enabled;
  logic lvl_mode;

  always_ff @(posedge clk) begin
    prev_q <= pin_i;
  end

  always_comb begin
    unique case (mode_i)
      DET_LOW:  hit = ~pin_i;
      DET_HIGH: hit = pin_i;
      DET_RISE: hit = pin_i & ~prev_q;
      DET_FALL: hit = ~pin_i & prev_q;
      default:  hit = 1'b0;
    endcase
  end

  assign enabled  = ~mask_i && (prio_i != '0);
  assign lvl_mode = mode_is_level(mode_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (!enabled) begin
      pend_q <= 1'b0;
    end else if (lvl_mode) begin
      pend_q <= acc_any_i ? 1'b0 : (pend_q | hit);
    end else if (hit) begin
      pend_q <= 1'b1;
    end else if (acc_hit_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pending_o = pend_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int ID_W  = 3
) (
  input  logic [N_SRC-1:0]       pending_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  input  logic [LVL_W-1:0]       cpu_mask_i,
  output logic                   any_o,
  output logic [ID_W-1:0]        id_o,
  output logic [LVL_W-1:0]       lvl_o
);

  logic [N_SRC-1:0] eligible;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_elig
      assign eligible[g] = pending_i[g] && (prio_i[g*LVL_W +: LVL_W] > cpu_mask_i);
    end
  endgenerate

  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    lvl_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && (prio_i[i*LVL_W +: LVL_W] >= lvl_o)) begin
        any_o = 1'b1;
        id_o  = ID_W'(i);
        lvl_o = prio_i[i*LVL_W +: LVL_W];
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       pin_i,
  input  logic [2*N_SRC-1:0]     mode_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  input  logic [LVL_W-1:0]       cpu_mask_i,
  input  logic [N_SRC-1:0]       src_mask_i,
  input  logic                   accept_i,
  input  logic [ID_W-1:0]        accept_id_i,
  output logic                   irq_valid_o,
  output logic [ID_W-1:0]        irq_id_o,
  output logic [LVL_W-1:0]       irq_level_o
);

  logic [N_SRC-1:0] pending_q;
  logic             arb_any;
  logic [ID_W-1:0]  arb_id;
  logic [LVL_W-1:0] arb_lvl;

  genvar s;
  generate
    for (s = 0; s < N_SRC; s++) begin : g_src
      irq_src_latch #(.LVL_W(LVL_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .pin_i     (pin_i[s]),
        .mode_i    (det_mode_e'(mode_i[2*s +: 2])),
        .prio_i    (prio_i[s*LVL_W +: LVL_W]),
        .mask_i    (src_mask_i[s]),
        .acc_hit_i (accept_i && (accept_id_i == ID_W'(s))),
        .acc_any_i (accept_i),
        .pending_o (pending_q[s])
      );
    end
  endgenerate

  irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
    .pending_i  (pending_q),
    .prio_i     (prio_i),
    .cpu_mask_i (cpu_mask_i),
    .any_o      (arb_any),
    .id_o       (arb_id),
    .lvl_o      (arb_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid_o <= 1'b0;
      irq_id_o    <= '0;
      irq_level_o <= '0;
    end else begin
      irq_valid_o <= arb_any;
      irq_id_o    <= arb_id;
      irq_level_o <= arb_lvl;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 4,
  parameter int ID_W  = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [2*N_SRC-1:0]     mode_i,
  input logic [N_SRC*LVL_W-1:0] prio_i,
  input logic [LVL_W-1:0]       cpu_mask_i,
  input logic [N_SRC-1:0]       src_mask_i,
  input logic                   accept_i,
  input logic                   irq_valid_o,
  input logic [ID_W-1:0]        irq_id_o,
  input logic [LVL_W-1:0]       irq_level_o,
  input logic [N_SRC-1:0]       pending_q
);

  logic [N_SRC-1:0]       lvl_vec;
  logic [N_SRC-1:0]       zero_vec;
  logic [N_SRC-1:0]       pend_d;
  logic [N_SRC*LVL_W-1:0] prio_d;
  logic [LVL_W-1:0]       win_prio;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      lvl_vec[i]  = (mode_i[2*i+1] == mode_i[2*i]);
      zero_vec[i] = (prio_i[i*LVL_W +: LVL_W] == '0);
    end
  end

  always_ff @(posedge clk) begin
    pend_d <= pending_q;
    prio_d <= prio_i;
  end

  assign win_prio = prio_d[irq_id_o*LVL_W +: LVL_W];

  p_above_mask_r7: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (irq_level_o > $past(cpu_mask_i)));

  p_level_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (irq_level_o != '0));

  p_from_pending_r10: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> pend_d[irq_id_o]);

  p_winner_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (irq_level_o == win_prio));

  p_mask_drops_r5: assert property (@(posedge clk) disable iff (rst)
    (src_mask_i != '0) |=> ((pending_q & $past(src_mask_i)) == '0));

  p_zero_prio_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (zero_vec != '0) |=> ((pending_q & $past(zero_vec)) == '0));

  p_accept_frees_level_r4: assert property (@(posedge clk) disable iff (rst)
    accept_i |=> ((pending_q & $past(lvl_vec)) == '0));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !irq_valid_o |-> (irq_id_o == '0 && irq_level_o == '0));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_i      (mode_i),
  .prio_i      (prio_i),
  .cpu_mask_i  (cpu_mask_i),
  .src_mask_i  (src_mask_i),
  .accept_i    (accept_i),
  .irq_valid_o (irq_valid_o),
  .irq_id_o    (irq_id_o),
  .irq_level_o (irq_level_o),
  .pending_q   (pending_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin = '0;
  logic [15:0] mode = {8{2'b10}};
  logic [31:0] prio = '0;
  logic [3:0]  cmask = '0;
  logic [7:0]  smask = '0;
  logic        acc = 1'b0;
  logic [2:0]  acc_id = '0;
  logic        vld;
  logic [2:0]  id;
  logic [3:0]  lvl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .mode_i(mode), .prio_i(prio),
    .cpu_mask_i(cmask), .src_mask_i(smask), .accept_i(acc),
    .accept_id_i(acc_id), .irq_valid_o(vld), .irq_id_o(id), .irq_level_o(lvl)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic ev, logic [2:0] eid, logic [3:0] el);
    checks++;
    if (vld !== ev || (ev && (id !== eid || lvl !== el))) begin
      fails++;
      $display("FAIL %s: got v=%0b id=%0d lvl=%0d, expected v=%0b id=%0d lvl=%0d",
               req, vld, id, lvl, ev, eid, el);
    end
  endtask

  task automatic cfg(int src, logic [1:0] m, logic [3:0] p);
    mode[2*src +: 2] = m;
    prio[4*src +: 4] = p;
  endtask

  task automatic pulse_acc(logic [2:0] which);
    acc = 1'b1; acc_id = which;
    @(posedge clk); @(negedge clk);
    acc = 1'b0;
  endtask

  task automatic quiet();
    pin = '0; prio = '0; mode = {8{2'b10}}; smask = '0; cmask = '0;
    tick(3);
  endtask

  task automatic t_reset();
    checks++;
    if (vld !== 1'b0 || id !== 3'd0 || lvl !== 4'd0) begin
      fails++;
      $display("FAIL R10: got v=%0b id=%0d lvl=%0d, expected all 0", vld, id, lvl);
    end
  endtask

  task automatic t_rising();
    cfg(2, 2'b10, 4'd5);
    tick(1);
    pin[2] = 1'b1;
    tick(1); chk("R11 not yet", 1'b0, 3'd0, 4'd0);
    tick(1); chk("R1 R11 rising", 1'b1, 3'd2, 4'd5);
    pin[2] = 1'b0;
    tick(2); chk("R1 edge held", 1'b1, 3'd2, 4'd5);
    pulse_acc(3'd2);
    tick(1); chk("R9 own accept", 1'b0, 3'd0, 4'd0);
    quiet();
  endtask

  task automatic t_falling();
    cfg(6, 2'b01, 4'd3);
    pin[6] = 1'b1;
    tick(3); chk("R1 rise ignored in fall mode", 1'b0, 3'd0, 4'd0);
    pin[6] = 1'b0;
    tick(2); chk("R1 falling", 1'b1, 3'd6, 4'd3);
    quiet();
  endtask

  task automatic t_low_level();
    pin[4] = 1'b1;
    cfg(4, 2'b00, 4'd7);
    tick(3); chk("R2 low inactive", 1'b0, 3'd0, 4'd0);
    pin[4] = 1'b0;
    tick(2); chk("R2 low active", 1'b1, 3'd4, 4'd7);
    pin[4] = 1'b1;
    tick(3); chk("R3 held after release", 1'b1, 3'd4, 4'd7);
    pulse_acc(3'd1);
    tick(1); chk("R4 other accept frees", 1'b0, 3'd0, 4'd0);
    tick(2); chk("R4 stays free", 1'b0, 3'd0, 4'd0);
    quiet();
  endtask

  task automatic t_high_relatch();
    cfg(3, 2'b11, 4'd9);
    pin[3] = 1'b1;
    tick(2); chk("R2 high", 1'b1, 3'd3, 4'd9);
    pulse_acc(3'd3);
    tick(1); chk("R4 released", 1'b0, 3'd0, 4'd0);
    tick(1); chk("R4 relatched", 1'b1, 3'd3, 4'd9);
    quiet();
  endtask

  task automatic t_edge_other();
    cfg(5, 2'b10, 4'd4);
    tick(1);
    pin[5] = 1'b1; tick(1); pin[5] = 1'b0;
    tick(2); chk("R1 pulse", 1'b1, 3'd5, 4'd4);
    pulse_acc(3'd0);
    tick(1); chk("R9 other accept keeps", 1'b1, 3'd5, 4'd4);
    pulse_acc(3'd5);
    tick(1); chk("R9 own accept clears", 1'b0, 3'd0, 4'd0);
    quiet();
  endtask

  task automatic t_mask();
    cfg(1, 2'b11, 4'd6);
    pin[1] = 1'b1;
    tick(2); chk("R5 before mask", 1'b1, 3'd1, 4'd6);
    smask[1] = 1'b1;
    tick(2); chk("R5 masked", 1'b0, 3'd0, 4'd0);
    tick(3); chk("R5 masked pin ignored", 1'b0, 3'd0, 4'd0);
    smask[1] = 1'b0;
    tick(2); chk("R5 unmask relatch", 1'b1, 3'd1, 4'd6);
    quiet();
    cfg(0, 2'b10, 4'd2);
    smask[0] = 1'b1;
    tick(1);
    pin[0] = 1'b1; tick(1); pin[0] = 1'b0;
    tick(3); chk("R5 masked edge", 1'b0, 3'd0, 4'd0);
    smask[0] = 1'b0;
    tick(3); chk("R5 edge not recovered", 1'b0, 3'd0, 4'd0);
    quiet();
  endtask

  task automatic t_prio_zero();
    cfg(7, 2'b10, 4'd0);
    tick(1);
    pin[7] = 1'b1; tick(1); pin[7] = 1'b0;
    tick(3); chk("R6 level 0 ignored", 1'b0, 3'd0, 4'd0);
    prio[28 +: 4] = 4'd8;
    tick(3); chk("R6 not recovered", 1'b0, 3'd0, 4'd0);
    quiet();
  endtask

  task automatic t_cpu_mask();
    cfg(2, 2'b11, 4'd5);
    pin[2] = 1'b1;
    cmask = 4'd5;
    tick(3); chk("R7 equal to mask blocked", 1'b0, 3'd0, 4'd0);
    cmask = 4'd4;
    tick(1); chk("R7 R11 above mask", 1'b1, 3'd2, 4'd5);
    cmask = 4'd15;
    tick(1); chk("R7 max mask", 1'b0, 3'd0, 4'd0);
    quiet();
  endtask

  task automatic t_priority();
    cfg(0, 2'b11, 4'd2); cfg(1, 2'b11, 4'd3);
    cfg(4, 2'b11, 4'd12); cfg(6, 2'b11, 4'd12);
    pin = 8'b0101_0011;
    tick(3); chk("R8 tie lower index", 1'b1, 3'd4, 4'd12);
    prio[24 +: 4] = 4'd13;
    tick(2); chk("R8 higher level", 1'b1, 3'd6, 4'd13);
    cmask = 4'd12;
    tick(2); chk("R7 R8 only top above", 1'b1, 3'd6, 4'd13);
    cmask = 4'd2;
    smask[6] = 1'b1;
    tick(2); chk("R8 next best", 1'b1, 3'd4, 4'd12);
    smask[4] = 1'b1;
    tick(2); chk("R8 then src1", 1'b1, 3'd1, 4'd3);
    quiet();
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_rising();
    t_falling();
    t_low_level();
    t_high_relatch();
    t_edge_other();
    t_mask();
    t_prio_zero();
    t_cpu_mask();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule